// File: doc/BRIEF.md
# Operating-Mode Sequencer for a Battery Authentication Device

This block decides which of four operating modes a small pack authentication device is in: communication, computation, programming or thermistor access. It takes command strobes already decoded by the serial front end, a flag from the high-voltage detector, the completion pulse of the hash engine and a power-good flag from the supply monitor. It drives one indicator per mode, plus three controls: one that isolates the bus interface, one that pulls the thermistor pin to ground, and one that enables non-volatile programming.

Communication mode is the resting state, and only in it are commands acted upon. A compute command moves the device into computation mode only if a challenge has been written since the last computation. Programming mode is reached only when the high-voltage flag rises within a bounded window that follows one of three programming-capable commands. Thermistor access is a one-way trip that ends only when the supply collapses and power-good drops, which resets the whole controller.

Top module: `opm_ctrl`

## Requirements
- R1: While `pwr_ok` is low the controller is held in communication mode at once, without waiting for a clock edge, and the challenge flag and high-voltage window are cleared.
- R2: Exactly one of `mode_comm`, `mode_comp`, `mode_prog`, `mode_thm` is high; `dq_disconnect` and `thm_drive_low` are high only in thermistor mode and `prog_en` only in programming mode.
- R3: In communication mode a strobe with code 3'd2 (compute MAC) or 3'd3 (compute next secret) moves the device to computation mode at that clock edge when a challenge is held; a strobe with code 3'd1 marks a challenge as held.
- R4: A compute strobe with no held challenge leaves the device in communication mode, and entering computation mode clears the held challenge, so a second compute needs a new challenge write.
- R5: In computation mode the device stays there until `hash_done` is sampled high, and then returns to communication mode at that edge.
- R6: After a strobe with code 3'd4 (compute secret), 3'd5 (load/lock secret) or 3'd6 (overdrive timing) at clock edge E0, a rising edge of `hv_det` sampled at any of edges E1 to E`WIN_CYC` puts the device in programming mode.
- R7: A rising edge of `hv_det` outside that window is ignored: with no preceding eligible command, at edge E`WIN_CYC`+1 or later, after any other command strobe has closed the window, or when `hv_det` was already high.
- R8: Programming mode lasts while `hv_det` stays high and returns to communication mode at the first edge where it is sampled low.
- R9: A strobe with code 3'd7 enters thermistor mode; from then on commands, `hash_done` and `hv_det` have no effect until `pwr_ok` goes low.
- R10: Command strobes that arrive in computation or programming mode are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| pwr_ok | input | 1 | Supply good; low resets the controller asynchronously |
| cmd_stb | input | 1 | One-cycle strobe for a decoded command |
| cmd_code | input | 3 | Command code, valid with `cmd_stb` |
| hv_det | input | 1 | High programming voltage present on the bus line |
| hash_done | input | 1 | Hash engine has finished its computation |
| mode_comm | output | 1 | Communication mode indicator |
| mode_comp | output | 1 | Computation mode indicator |
| mode_prog | output | 1 | Programming mode indicator |
| mode_thm | output | 1 | Thermistor access mode indicator |
| dq_disconnect | output | 1 | Isolate the serial bus interface |
| thm_drive_low | output | 1 | Pull the thermistor pin to ground |
| prog_en | output | 1 | Route programming voltage to the non-volatile array |

## Verification
The bench puts the high-voltage rise on the last edge inside the window and on the first edge past it; a counter off by one would enter programming in the second case or miss the first. It raises the voltage before an eligible command and holds it, which a level-sensitive design would wrongly accept, and it closes the window with an unrelated command. It issues a second compute without a new challenge, which a design that forgot to consume the challenge would run. It also throws commands, hash completions and voltage pulses at thermistor and computation modes, where a design that leaked any of them would leave the mode early.

// File: rtl/opm_pkg.sv
package opm_pkg;

    typedef enum logic [1:0] {
        M_COMM = 2'd0,
        M_COMP = 2'd1,
        M_PROG = 2'd2,
        M_THM  = 2'd3
    } mode_e;

    localparam int CMD_W = 3;

    localparam logic [CMD_W-1:0] CMD_NOP       = 3'd0;
    localparam logic [CMD_W-1:0] CMD_CHAL_WR   = 3'd1;
    localparam logic [CMD_W-1:0] CMD_MAC       = 3'd2;
    localparam logic [CMD_W-1:0] CMD_NEXT_KEY  = 3'd3;
    localparam logic [CMD_W-1:0] CMD_GEN_KEY   = 3'd4;
    localparam logic [CMD_W-1:0] CMD_KEY_STORE = 3'd5;
    localparam logic [CMD_W-1:0] CMD_SPEED_CFG = 3'd6;
    localparam logic [CMD_W-1:0] CMD_THERM     = 3'd7;

    typedef struct packed {
        mode_e mode;
        logic  chal;
        logic  hv;
    } ctl_s;

endpackage

// File: rtl/opm_hv_window.sv
module opm_hv_window #(
    parameter int WIN_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic open_i,
    input  logic close_i,
    output logic win_o
);
    localparam int CNT_W = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;

    typedef struct packed {
        logic             open;
        logic [CNT_W-1:0] cnt;
    } win_s;

    win_s win_d, win_q;

    always_comb begin
        win_d = win_q;
        if (close_i) begin
            win_d.open = 1'b0;
            win_d.cnt  = '0;
        end else if (open_i) begin
            win_d.open = 1'b1;
            win_d.cnt  = CNT_W'(WIN_CYC - 1);
        end else if (win_q.open) begin
            if (win_q.cnt == '0) begin
                win_d.open = 1'b0;
            end else begin
                win_d.cnt = win_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
        end else begin
            win_q <= win_d;
        end
    end

    assign win_o = win_q.open;

    // R7: window never outlives its last count
    a_r7_window_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (win_q.open && win_q.cnt == '0 && !open_i) |=> !win_q.open);

    // R6: an eligible command always opens the window
    a_r6_window_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (open_i && !close_i) |=> win_q.open);

endmodule

// File: rtl/opm_out_decode.sv
module opm_out_decode
    import opm_pkg::*;
(
    input  mode_e mode_i,
    output logic  mode_comm,
    output logic  mode_comp,
    output logic  mode_prog,
    output logic  mode_thm,
    output logic  dq_disconnect,
    output logic  thm_drive_low,
    output logic  prog_en
);
    always_comb begin
        mode_comm = (mode_i == M_COMM);
        mode_comp = (mode_i == M_COMP);
        mode_prog = (mode_i == M_PROG);
        mode_thm  = (mode_i == M_THM);
    end

    assign dq_disconnect = mode_thm;
    assign thm_drive_low = mode_thm;
    assign prog_en       = mode_prog;

    // R2: programming and thermistor controls never overlap
    always_comb begin
        a_r2_ctrl_exclusive: assert (!(prog_en && (dq_disconnect || thm_drive_low)));
    end

endmodule

// File: rtl/opm_ctrl.sv
module opm_ctrl
    import opm_pkg::*;
#(
    parameter int WIN_CYC = 16
) (
    input  logic             clk,
    input  logic             pwr_ok,
    input  logic             cmd_stb,
    input  logic [CMD_W-1:0] cmd_code,
    input  logic             hv_det,
    input  logic             hash_done,
    output logic             mode_comm,
    output logic             mode_comp,
    output logic             mode_prog,
    output logic             mode_thm,
    output logic             dq_disconnect,
    output logic             thm_drive_low,
    output logic             prog_en
);
    ctl_s st_d, st_q;
    logic win;
    logic win_open;
    logic win_close;
    logic hv_rise;
    logic cmd_ok;

    assign hv_rise = hv_det && !st_q.hv;
    assign cmd_ok  = cmd_stb && (st_q.mode == M_COMM);

    always_comb begin
        st_d      = st_q;
        st_d.hv   = hv_det;
        win_open  = 1'b0;
        win_close = 1'b0;
        unique case (st_q.mode)
            M_COMM: begin
                if (hv_rise && win) begin
                    st_d.mode = M_PROG;
                    win_close = 1'b1;
                end else if (cmd_ok) begin
                    unique case (cmd_code)
                        CMD_CHAL_WR: begin
                            st_d.chal = 1'b1;
                            win_close = 1'b1;
                        end
                        CMD_MAC, CMD_NEXT_KEY: begin
                            if (st_q.chal) begin
                                st_d.mode = M_COMP;
                                st_d.chal = 1'b0;
                            end
                            win_close = 1'b1;
                        end
                        CMD_GEN_KEY, CMD_KEY_STORE, CMD_SPEED_CFG: begin
                            win_open = 1'b1;
                        end
                        CMD_THERM: begin
                            st_d.mode = M_THM;
                            win_close = 1'b1;
                        end
                        default: begin
                            win_close = 1'b1;
                        end
                    endcase
                end
            end
            M_COMP: begin
                if (hash_done) begin
                    st_d.mode = M_COMM;
                end
            end
            M_PROG: begin
                if (!hv_det) begin
                    st_d.mode = M_COMM;
                end
            end
            M_THM: begin
                st_d.mode = M_THM;
            end
            default: begin
                st_d.mode = M_COMM;
            end
        endcase
    end

    always_ff @(posedge clk or negedge pwr_ok) begin
        if (!pwr_ok) begin
            st_q <= '{mode: M_COMM, chal: 1'b0, hv: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    opm_hv_window #(
        .WIN_CYC(WIN_CYC)
    ) u_win (
        .clk    (clk),
        .rst_n  (pwr_ok),
        .open_i (win_open),
        .close_i(win_close),
        .win_o  (win)
    );

    opm_out_decode u_dec (
        .mode_i       (st_q.mode),
        .mode_comm    (mode_comm),
        .mode_comp    (mode_comp),
        .mode_prog    (mode_prog),
        .mode_thm     (mode_thm),
        .dq_disconnect(dq_disconnect),
        .thm_drive_low(thm_drive_low),
        .prog_en      (prog_en)
    );

    // R9: thermistor mode is left only through power loss
    a_r9_thm_sticky: assert property (@(posedge clk) disable iff (!pwr_ok)
        mode_thm |=> mode_thm);

    // R5: hash completion ends computation
    a_r5_comp_exit: assert property (@(posedge clk) disable iff (!pwr_ok)
        (mode_comp && hash_done) |=> mode_comm);

    // R8: loss of high voltage ends programming
    a_r8_prog_exit: assert property (@(posedge clk) disable iff (!pwr_ok)
        (mode_prog && !hv_det) |=> mode_comm);

    // R6: programming is entered only from an open window with the voltage present
    a_r6_prog_entry: assert property (@(posedge clk) disable iff (!pwr_ok)
        $rose(mode_prog) |-> ($past(win) && $past(hv_det)));

    // R4: computation needs a held challenge
    a_r4_comp_needs_chal: assert property (@(posedge clk) disable iff (!pwr_ok)
        $rose(mode_comp) |-> $past(st_q.chal));

    // R10: commands do not move the device out of computation
    a_r10_comp_ignores_cmd: assert property (@(posedge clk) disable iff (!pwr_ok)
        (mode_comp && !hash_done) |=> mode_comp);

endmodule

// File: tb/tb_opm_ctrl.sv
module tb_opm_ctrl;
    localparam int WIN_CYC = 16;

    logic       clk = 1'b0;
    logic       pwr_ok = 1'b0;
    logic       cmd_stb = 1'b0;
    logic [2:0] cmd_code = 3'd0;
    logic       hv_det = 1'b0;
    logic       hash_done = 1'b0;
    logic       mode_comm, mode_comp, mode_prog, mode_thm;
    logic       dq_disconnect, thm_drive_low, prog_en;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    opm_ctrl #(.WIN_CYC(WIN_CYC)) dut (
        .clk(clk), .pwr_ok(pwr_ok), .cmd_stb(cmd_stb), .cmd_code(cmd_code),
        .hv_det(hv_det), .hash_done(hash_done),
        .mode_comm(mode_comm), .mode_comp(mode_comp), .mode_prog(mode_prog),
        .mode_thm(mode_thm), .dq_disconnect(dq_disconnect),
        .thm_drive_low(thm_drive_low), .prog_en(prog_en)
    );

    // expected mode as {comm, comp, prog, thm}
    localparam logic [3:0] E_COMM = 4'b1000;
    localparam logic [3:0] E_COMP = 4'b0100;
    localparam logic [3:0] E_PROG = 4'b0010;
    localparam logic [3:0] E_THM  = 4'b0001;

    task automatic chk_mode(input logic [3:0] exp, input string req);
        logic [3:0] act;
        logic [2:0] ctl, ectl;
        act  = {mode_comm, mode_comp, mode_prog, mode_thm};
        ctl  = {dq_disconnect, thm_drive_low, prog_en};
        ectl = {exp[0], exp[0], exp[1]};
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s mode actual=%b expected=%b", req, act, exp);
        end
        checks++;
        if (ctl !== ectl) begin
            failures++;
            $display("FAIL %s/R2 controls actual=%b expected=%b", req, ctl, ectl);
        end
    endtask

    task automatic send_cmd(input logic [2:0] code);
        @(negedge clk);
        cmd_stb  = 1'b1;
        cmd_code = code;
        @(negedge clk);
        cmd_stb  = 1'b0;
        cmd_code = 3'd0;
    endtask

    task automatic power_cycle();
        @(negedge clk);
        pwr_ok = 1'b0;
        #1;
    endtask

    task automatic power_up();
        @(negedge clk);
        pwr_ok = 1'b1;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        hash_done = 1'b1;
        @(negedge clk);
        hash_done = 1'b0;
    endtask

    task automatic t_reset();
        power_cycle();
        chk_mode(E_COMM, "R1 reset");
        power_up();
        @(negedge clk);
        chk_mode(E_COMM, "R1 after release");
    endtask

    task automatic t_compute();
        send_cmd(3'd2);
        chk_mode(E_COMM, "R4 compute without challenge");
        send_cmd(3'd1);
        chk_mode(E_COMM, "R3 challenge write");
        send_cmd(3'd2);
        chk_mode(E_COMP, "R3 compute MAC");
        repeat (5) @(negedge clk);
        chk_mode(E_COMP, "R5 held until done");
        send_cmd(3'd7);
        chk_mode(E_COMP, "R10 command in computation");
        pulse_done();
        chk_mode(E_COMM, "R5 done returns");
        send_cmd(3'd2);
        chk_mode(E_COMM, "R4 challenge consumed");
        send_cmd(3'd1);
        send_cmd(3'd3);
        chk_mode(E_COMP, "R3 compute next secret");
        pulse_done();
        chk_mode(E_COMM, "R5 done after next secret");
    endtask

    task automatic t_hv_outside();
        @(negedge clk);
        hv_det = 1'b1;
        @(negedge clk);
        chk_mode(E_COMM, "R7 hv without command");
        hv_det = 1'b0;
        @(negedge clk);
        // voltage already high before the command: no rise in window
        hv_det = 1'b1;
        send_cmd(3'd4);
        repeat (3) @(negedge clk);
        chk_mode(E_COMM, "R7 hv already high");
        hv_det = 1'b0;
        repeat (WIN_CYC + 2) @(negedge clk);
    endtask

    task automatic prog_at(input logic [2:0] code, input int k, input logic [3:0] exp,
                           input string req);
        send_cmd(code);
        repeat (k - 1) @(negedge clk);
        hv_det = 1'b1;
        @(negedge clk);
        chk_mode(exp, req);
        if (exp == E_PROG) begin
            repeat (4) @(negedge clk);
            chk_mode(E_PROG, "R8 held while hv high");
            send_cmd(3'd7);
            chk_mode(E_PROG, "R10 command in programming");
        end
        hv_det = 1'b0;
        @(negedge clk);
        chk_mode(E_COMM, "R8 hv low returns");
        repeat (WIN_CYC + 2) @(negedge clk);
    endtask

    task automatic t_program();
        prog_at(3'd4, 1, E_PROG, "R6 compute secret");
        prog_at(3'd5, 1, E_PROG, "R6 load lock secret");
        prog_at(3'd6, 1, E_PROG, "R6 overdrive timing");
        prog_at(3'd4, WIN_CYC, E_PROG, "R6 last window edge");
        prog_at(3'd5, WIN_CYC + 1, E_COMM, "R7 past window");
        prog_at(3'd0, 1, E_COMM, "R7 ineligible command");
    endtask

    task automatic t_cancel();
        send_cmd(3'd6);
        send_cmd(3'd0);
        hv_det = 1'b1;
        @(negedge clk);
        chk_mode(E_COMM, "R7 window closed by other command");
        hv_det = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_thermistor();
        send_cmd(3'd7);
        chk_mode(E_THM, "R9 enter thermistor");
        send_cmd(3'd1);
        send_cmd(3'd2);
        pulse_done();
        send_cmd(3'd4);
        hv_det = 1'b1;
        repeat (2) @(negedge clk);
        hv_det = 1'b0;
        repeat (3) @(negedge clk);
        chk_mode(E_THM, "R9 thermistor sticky");
        power_cycle();
        chk_mode(E_COMM, "R1 power loss leaves thermistor");
        power_up();
        @(negedge clk);
        send_cmd(3'd2);
        chk_mode(E_COMM, "R1 challenge cleared by power loss");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_compute();
        t_hv_outside();
        t_program();
        t_cancel();
        t_thermistor();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule